// File: doc/BRIEF.md
# Privilege-Masked Status Flag Restore

This block holds a 32-bit processor status-flag word and reloads it from a value taken off the stack. For each bit, it decides whether the incoming value may change that bit. The decision uses the operating mode, the current privilege level, the two-bit I/O privilege field already in the register, and the operand size. Some bits take the new value. Some keep their old value without any fault. The two virtual-interrupt bits are forced to zero. In virtual mode, when the I/O privilege field is below 3, the whole restore is refused and a general-protection fault pulse is raised.

The restore arrives on a valid/ready input. Ready is always high, so there is no back-pressure: a word presented with valid high is taken on the next rising clock edge. The fault pulse is combinational and appears in the same cycle as the refused word. The current register value is always visible on a plain output, which a push operation reads. Stack memory, instruction decode and exception delivery are outside this block.

Bit layout: carry 0, parity 2, adjust 4, zero 6, sign 7, trap 8, interrupt-enable 9, direction 10, overflow 11, I/O privilege 13:12, nested 14, resume 16, virtual-mode 17, alignment 18, virtual-interrupt 19, virtual-interrupt-pending 20, identify 21. Mode codes: 00 real, 01 protected, 10 virtual, 11 handled as protected.

Top module: `flag_restore`

## Requirements
- R1: After reset the register reads 32'h0000_0002, and `rst_ready` is high in every cycle.
- R2: A 32-bit restore in protected mode at privilege 0 writes every non-reserved bit except bits 19 and 20.
- R3: A 16-bit restore (`op32`=0) writes only bits 15:0 under the same per-bit rules. Bits 31:16 keep their previous value, including bits 19 and 20.
- R4: Any accepted 32-bit restore outside virtual mode leaves bits 19 and 20 at zero.
- R5: In protected mode at a privilege level above 0, the I/O privilege field (bits 13:12) keeps its value.
- R6: Outside real mode, the interrupt-enable bit 9 is written only when `cpl` <= the current I/O privilege field. Otherwise it keeps its value and no fault is raised.
- R7: In virtual mode with the I/O privilege field below 3, `gp_fault` is high in the cycle the word is presented, and no bit of the register changes.
- R8: In virtual mode with the I/O privilege field equal to 3, there is no fault. Bits 16, 17, 13:12, 19 and 20 keep their values, and all other non-reserved bits in range are written.
- R9: In real mode, privilege is treated as 0, so bit 9 and bits 13:12 are written whatever `cpl` is. Bits 16 and 17 keep their values.
- R10: With `rst_valid` low, the register holds its value whatever the other inputs are, and `gp_fault` stays low.
- R11: Mode code 11 behaves exactly like protected mode.
- R12: Reserved bits cannot be written. Bit 1 always reads 1, and bits 3, 5, 15 and 31:22 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| rst_valid | input | 1 | Restore word valid |
| rst_ready | output | 1 | Always high; the restore is never stalled |
| rst_word | input | 32 | Word popped from the stack |
| mode | input | 2 | Operating mode: 00 real, 01 protected, 10 virtual, 11 as protected |
| cpl | input | 2 | Current privilege level |
| op32 | input | 1 | 1 = 32-bit operand size, 0 = 16-bit |
| flags | output | 32 | Current register value, used as the read port for pushes |
| gp_fault | output | 1 | One-cycle general-protection fault for a refused restore |

## Verification
The assertions check the following in every cycle: reserved-bit constants, holding while idle, holding on a fault, when a fault may occur, the upper half staying fixed on 16-bit restores, clearing of bits 19 and 20, and the held I/O privilege field and interrupt bit at raised privilege. Only the bench scenarios can show that permitted bits really take the popped value. This covers real mode ignoring `cpl`, virtual mode writing its unlocked bits, and whole sequences in which the I/O privilege field set by one restore gates the next one.

// File: rtl/flgr_pkg.sv
package flgr_pkg;

  localparam int FLAG_W = 32;

  localparam int B_CARRY  = 0;
  localparam int B_ONE    = 1;
  localparam int B_PAR    = 2;
  localparam int B_ADJ    = 4;
  localparam int B_ZERO   = 6;
  localparam int B_SIGN   = 7;
  localparam int B_TRAP   = 8;
  localparam int B_INTEN  = 9;
  localparam int B_DIR    = 10;
  localparam int B_OVF    = 11;
  localparam int B_IOL_LO = 12;
  localparam int B_IOL_HI = 13;
  localparam int B_NEST   = 14;
  localparam int B_RESUME = 16;
  localparam int B_VMODE  = 17;
  localparam int B_ALIGN  = 18;
  localparam int B_VINT   = 19;
  localparam int B_VPEND  = 20;
  localparam int B_IDENT  = 21;

  typedef enum logic [1:0] {
    MODE_REAL = 2'b00,
    MODE_PROT = 2'b01,
    MODE_VIRT = 2'b10,
    MODE_ALT  = 2'b11
  } run_mode_e;

  // one-hot mask of a single bit position
  function automatic logic [FLAG_W-1:0] bitm(input int pos);
    logic [FLAG_W-1:0] m;
    m = '0;
    m[pos] = 1'b1;
    return m;
  endfunction

  // bits that a restore may ever touch
  function automatic logic [FLAG_W-1:0] live_mask();
    return bitm(B_CARRY) | bitm(B_PAR) | bitm(B_ADJ) | bitm(B_ZERO) |
           bitm(B_SIGN) | bitm(B_TRAP) | bitm(B_INTEN) | bitm(B_DIR) |
           bitm(B_OVF) | bitm(B_IOL_LO) | bitm(B_IOL_HI) | bitm(B_NEST) |
           bitm(B_RESUME) | bitm(B_VMODE) | bitm(B_ALIGN) | bitm(B_VINT) |
           bitm(B_VPEND) | bitm(B_IDENT);
  endfunction

  function automatic logic [FLAG_W-1:0] vint_mask();
    return bitm(B_VINT) | bitm(B_VPEND);
  endfunction

  function automatic logic [FLAG_W-1:0] iol_mask();
    return bitm(B_IOL_LO) | bitm(B_IOL_HI);
  endfunction

  function automatic logic [FLAG_W-1:0] vm_rf_mask();
    return bitm(B_RESUME) | bitm(B_VMODE);
  endfunction

  localparam logic [FLAG_W-1:0] FIXED_ONE = 32'h0000_0002;
  localparam logic [FLAG_W-1:0] RESET_VAL = FIXED_ONE;

endpackage

// File: rtl/flgr_policy.sv
module flgr_policy
  import flgr_pkg::*;
#(
  parameter int W = FLAG_W
) (
  input  logic         valid,
  input  logic [1:0]   mode,
  input  logic [1:0]   cpl,
  input  logic [1:0]   iol_cur,
  input  logic         op32,
  output logic [W-1:0] wr_en,
  output logic [W-1:0] clr_en,
  output logic         reject,
  output logic         load
);

  localparam int HALF = W / 2;
  localparam logic [W-1:0] UPPER = {{(W-HALF){1'b1}}, {HALF{1'b0}}};

  logic is_real;
  logic is_virt;
  logic is_prot;
  logic priv0;
  logic int_ok;
  logic [W-1:0] keep;

  always_comb begin
    is_real = (mode == MODE_REAL);
    is_virt = (mode == MODE_VIRT);
    is_prot = !is_real && !is_virt;   // code 11 joins protected
    priv0   = is_real || (is_prot && cpl == 2'd0);
    int_ok  = is_real || (cpl <= iol_cur);
  end

  assign reject = valid && is_virt && (iol_cur != 2'b11);
  assign load   = valid && !reject;

  always_comb begin
    keep = '0;
    if (is_virt) keep = keep | vm_rf_mask() | iol_mask() | vint_mask();
    if (is_real) keep = keep | vm_rf_mask() | vint_mask();
    if (is_prot) begin
      keep = keep | vint_mask();
      if (!priv0) keep = keep | iol_mask();
    end
    if (!int_ok) keep = keep | bitm(B_INTEN);
    if (!op32)   keep = keep | UPPER;
  end

  assign wr_en  = load ? (live_mask() & ~keep) : '0;
  assign clr_en = (load && op32 && !is_virt) ? vint_mask() : '0;

endmodule

// File: rtl/flgr_merge.sv
module flgr_merge
  import flgr_pkg::*;
#(
  parameter int W = FLAG_W
) (
  input  logic [W-1:0] old_q,
  input  logic [W-1:0] word,
  input  logic [W-1:0] wr_en,
  input  logic [W-1:0] clr_en,
  output logic [W-1:0] next_q
);

  localparam logic [W-1:0] LIVE = live_mask();

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (FIXED_ONE[i]) begin : g_one
      assign next_q[i] = 1'b1;
    end else if (!LIVE[i]) begin : g_zero
      assign next_q[i] = 1'b0;
    end else begin : g_live
      assign next_q[i] = clr_en[i] ? 1'b0 : (wr_en[i] ? word[i] : old_q[i]);
    end
  end

endmodule

// File: rtl/flgr_state.sv
module flgr_state #(
  parameter int              W   = 32,
  parameter logic [W-1:0]    RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] next_q,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (!rst_n)    q <= RST;
    else if (load) q <= next_q;
  end

endmodule

// File: rtl/flag_restore.sv
module flag_restore
  import flgr_pkg::*;
#(
  parameter int W = FLAG_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rst_valid,
  output logic         rst_ready,
  input  logic [W-1:0] rst_word,
  input  logic [1:0]   mode,
  input  logic [1:0]   cpl,
  input  logic         op32,
  output logic [W-1:0] flags,
  output logic         gp_fault
);

  logic [W-1:0] q;
  logic [W-1:0] next_q;
  logic [W-1:0] wr_en;
  logic [W-1:0] clr_en;
  logic         reject;
  logic         load;

  assign rst_ready = 1'b1;

  flgr_policy #(.W(W)) u_policy (
    .valid   (rst_valid),
    .mode    (mode),
    .cpl     (cpl),
    .iol_cur (q[B_IOL_HI:B_IOL_LO]),
    .op32    (op32),
    .wr_en   (wr_en),
    .clr_en  (clr_en),
    .reject  (reject),
    .load    (load)
  );

  flgr_merge #(.W(W)) u_merge (
    .old_q  (q),
    .word   (rst_word),
    .wr_en  (wr_en),
    .clr_en (clr_en),
    .next_q (next_q)
  );

  flgr_state #(.W(W), .RST(RESET_VAL)) u_state (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (load),
    .next_q (next_q),
    .q      (q)
  );

  assign flags    = q;
  assign gp_fault = reject;

endmodule

// File: rtl/flag_restore_chk.sv
module flag_restore_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        rst_valid,
  input logic [31:0] rst_word,
  input logic [1:0]  mode,
  input logic [1:0]  cpl,
  input logic        op32,
  input logic [31:0] flags,
  input logic        gp_fault
);

  p_reserved_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[1] && !flags[3] && !flags[5] && !flags[15] && flags[31:22] == '0));

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_valid |=> $stable(flags));

  p_idle_nofault_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_valid |-> !gp_fault);

  p_fault_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    gp_fault |=> $stable(flags));

  p_fault_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    gp_fault |-> (mode == 2'b10 && flags[13:12] != 2'b11));

  p_upper_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_valid && !op32) |=> flags[31:16] == $past(flags[31:16]));

  p_vint_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_valid && op32 && mode != 2'b10) |=> flags[20:19] == 2'b00);

  p_iol_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_valid && mode[0] && cpl != 2'd0) |=> $stable(flags[13:12]));

  p_int_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_valid && mode != 2'b00 && cpl > flags[13:12]) |=> $stable(flags[9]));

  p_virt_lock_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_valid && mode == 2'b10) |=>
      ($stable(flags[17:16]) && $stable(flags[13:12]) && $stable(flags[20:19])));

  p_real_lock_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_valid && mode == 2'b00) |=> $stable(flags[17:16]));

endmodule

bind flag_restore flag_restore_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rst_valid (rst_valid),
  .rst_word  (rst_word),
  .mode      (mode),
  .cpl       (cpl),
  .op32      (op32),
  .flags     (flags),
  .gp_fault  (gp_fault)
);

// File: tb/test_flag_restore.sv
module test_flag_restore;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rst_valid = 1'b0;
  logic        rst_ready;
  logic [31:0] rst_word = '0;
  logic [1:0]  mode = 2'b00;
  logic [1:0]  cpl = 2'b00;
  logic        op32 = 1'b1;
  logic [31:0] flags;
  logic        gp_fault;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  typedef struct {
    logic [31:0] exp_flags;
    logic        exp_fault;
    string       tag;
  } item_t;

  item_t sb[$];
  logic [31:0] mdl = 32'h0000_0002;

  always #4 clk = ~clk;   // 125 MHz

  flag_restore i_flag_restore (
    .clk(clk), .rst_n(rst_n), .rst_valid(rst_valid), .rst_ready(rst_ready),
    .rst_word(rst_word), .mode(mode), .cpl(cpl), .op32(op32),
    .flags(flags), .gp_fault(gp_fault)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Expected-value model written from the requirement list, bit by bit.
  function automatic logic [31:0] predict(logic [31:0] old, logic [31:0] w,
                                          logic [1:0] md, logic [1:0] pl,
                                          logic o32, output logic flt);
    logic [31:0] nv;
    logic [1:0]  iol;
    nv  = old;
    iol = old[13:12];
    flt = 1'b0;
    if (md == 2'b10 && iol != 2'b11) begin
      flt = 1'b1;                          // R7
      return old;
    end
    for (int i = 0; i < 32; i++) begin
      bit wr;
      wr = 1'b1;
      if (i == 1 || i == 3 || i == 5 || i == 15 || i >= 22) wr = 1'b0; // R12
      if (!o32 && i >= 16) wr = 1'b0;                                   // R3
      if (md == 2'b10 && (i == 16 || i == 17 || i == 12 || i == 13 ||
                          i == 19 || i == 20)) wr = 1'b0;               // R8
      if (md == 2'b00 && (i == 16 || i == 17)) wr = 1'b0;               // R9
      if (md != 2'b10 && (i == 19 || i == 20)) begin                    // R4
        wr = 1'b0;
        if (o32) nv[i] = 1'b0;
      end
      if ((md == 2'b01 || md == 2'b11) && pl != 0 && (i == 12 || i == 13))
        wr = 1'b0;                                                      // R5
      if (md != 2'b00 && i == 9 && pl > iol) wr = 1'b0;                 // R6
      if (wr) nv[i] = w[i];
    end
    return nv;
  endfunction

  task automatic drive(bit v, logic [31:0] w, logic [1:0] md, logic [1:0] pl,
                       bit o32, string tag);
    item_t it;
    logic  f;
    @(negedge clk);
    rst_valid = v; rst_word = w; mode = md; cpl = pl; op32 = o32;
    if (v) begin
      it.exp_flags = predict(mdl, w, md, pl, o32, f);
      it.exp_fault = f;
    end else begin
      it.exp_flags = mdl;
      it.exp_fault = 1'b0;
    end
    mdl = it.exp_flags;
    it.tag = tag;
    sb.push_back(it);
  endtask

  // monitor: fault mid-low-phase, register one step after the edge
  initial begin
    forever begin
      item_t it;
      @(negedge clk);
      #2;
      if (sb.size() > 0) begin
        it = sb.pop_front();
        check({it.tag, " fault"}, {31'b0, gp_fault}, {31'b0, it.exp_fault});
        @(posedge clk);
        #1;
        check({it.tag, " flags"}, flags, it.exp_flags);
      end
    end
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] lf;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #2;
    check("R1 reset value", flags, 32'h0000_0002);
    check("R1 ready", {31'b0, rst_ready}, 32'h1);

    // R2: protected, privilege 0, all ones
    drive(1, 32'hFFFF_FFFF, 2'b01, 2'd0, 1, "R2");
    // R12: all zeros, bit 1 stays set
    drive(1, 32'h0000_0000, 2'b01, 2'd0, 1, "R12");
    drive(1, 32'hFFFF_FFFF, 2'b01, 2'd0, 1, "R12 ones");
    // R3: 16-bit restore keeps upper half
    drive(1, 32'h0000_A5A5, 2'b01, 2'd0, 0, "R3");
    drive(1, 32'h0000_0000, 2'b00, 2'd0, 0, "R3 real");
    // R4: vint bits cleared from a word that sets them
    drive(1, 32'h0018_0000, 2'b00, 2'd0, 1, "R4");
    // R5: set field to 0 at privilege 0, then try to raise it at privilege 2
    drive(1, 32'h0000_0000, 2'b01, 2'd0, 1, "R5 setup");
    drive(1, 32'h0000_3000, 2'b01, 2'd2, 1, "R5");
    // R6: field = 1, privilege 2 cannot set bit 9, privilege 1 can
    drive(1, 32'h0000_1000, 2'b01, 2'd0, 1, "R6 setup");
    drive(1, 32'h0000_1200, 2'b01, 2'd2, 1, "R6 held");
    drive(1, 32'h0000_1200, 2'b01, 2'd1, 1, "R6 written");
    // R7: virtual with field 1 -> fault, nothing changes
    drive(1, 32'hFFFF_FFFF, 2'b10, 2'd3, 1, "R7");
    drive(1, 32'h0000_0000, 2'b10, 2'd3, 0, "R7 16b");
    // R8: field 3 plus resume, virtual-mode bits set; then virtual restore
    drive(1, 32'h0003_3200, 2'b01, 2'd0, 1, "R8 setup");
    drive(1, 32'h0000_0000, 2'b10, 2'd3, 1, "R8");
    drive(1, 32'h0018_0CD5, 2'b10, 2'd3, 1, "R8 ones");
    // R9: real mode with cpl 3 still writes field and bit 9
    drive(1, 32'h0000_0000, 2'b00, 2'd3, 1, "R9 clear");
    drive(1, 32'h0000_3200, 2'b00, 2'd3, 1, "R9");
    // R10: idle with noise on inputs
    drive(0, 32'hFFFF_FFFF, 2'b10, 2'd3, 1, "R10");
    drive(0, 32'h0000_0000, 2'b01, 2'd0, 0, "R10 b");
    // R11: mode 11 acts as protected
    drive(1, 32'h0000_0000, 2'b11, 2'd0, 1, "R11 setup");
    drive(1, 32'hFFFF_FFFF, 2'b11, 2'd1, 1, "R11");

    // mixed sequence
    lf = 32'h1D2C_3B4A;
    for (int k = 0; k < 60; k++) begin
      logic [1:0] md;
      string tg;
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      md = lf[5:4];
      case (md)
        2'b00:   tg = "R9 mix";
        2'b01:   tg = "R2 mix";
        2'b10:   tg = (mdl[13:12] == 2'b11) ? "R8 mix" : "R7 mix";
        default: tg = "R11 mix";
      endcase
      drive(lf[9] | lf[10], lf, md, lf[7:6], lf[8], tg);
    end

    @(negedge clk);
    rst_valid = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule